// File: doc/BRIEF.md
# Dual-Field Pipelined Binary Field Multiplier

This block multiplies two elements of a binary extension field and returns their product reduced by the field polynomial. It supports two field sizes: a 16-bit field and a 14-bit field. A per-operation select input picks the field. Each field has its own unrolled multiply-and-reduce datapath. Both datapaths hang off the same 16-bit operand and product ports, and multiplexers at the input and output choose between them.

The reduction is split by a pipeline register. The first stage forms the carry-less product and folds away its highest-degree terms. The second stage folds the remaining terms above the field width. A new operand pair can be accepted on every clock, and every product appears exactly two cycles after its operands. The valid flag and the field select travel down the pipeline beside the data, so consecutive operations may use different fields.

The block is meant to be dropped into algebraic decoder datapaths, such as syndrome, key-equation or root-search units. There it sustains one multiplication per cycle.

Top module: `gf_dual_mul`

## Requirements
- R1: With `fieldSel`=1, the product equals opA·opB reduced modulo x^16+x^5+x^3+x^2+1, using all 16 operand bits, with bit i being the coefficient of x^i.
- R2: With `fieldSel`=0, the product equals opA[13:0]·opB[13:0] reduced modulo x^14+x^5+x^3+x+1, with bit i being the coefficient of x^i.
- R3: An operation accepted on a rising edge with `validIn`=1 raises `validOut` with its product exactly two rising edges later. Idle cycles on the input appear as idle cycles on the output with the same spacing.
- R4: A new operation is accepted on every cycle. Back-to-back operations that alternate between the two fields on every cycle each produce their own correct result.
- R5: In the 14-bit field, operand bits 15:14 have no effect on the result, and product bits 15:14 are zero.
- R6: While `validOut` is 0, `product` is all zeros.
- R7: While `rstN` is low (asynchronous, active low), `validOut` is 0 and `product` is zero.
- R8: A zero operand yields a zero product, and multiplying by 1 returns the other operand unchanged (within the selected field width).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Operand pair present this cycle |
| fieldSel | input | 1 | 1 = 16-bit field, 0 = 14-bit field |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| validOut | output | 1 | Product present this cycle |
| product | output | 16 | Reduced product, zero when not valid |

## Verification
The bench builds the block with its default parameters: a 16-bit wide field and a 14-bit narrow field with the two polynomials above. This setting brings within reach the reduction wrap-around at both top degrees, such as x^15·x in the wide field and x^13·x in the narrow one. It also brings in the all-ones operands that exercise every fold of both pipeline stages. Long random streams change field on every cycle and insert random bubbles. Against a bit-serial reference, these streams expose any lane cross-talk, mis-steered output multiplexer or latency skew. Narrow-field operands carry random junk in their top two bits, to show that those bits are ignored.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

  localparam int unsigned WIDE_W   = 16;
  localparam int unsigned NARROW_W = 14;

  // low-order coefficients of the field polynomials (leading term implied)
  localparam logic [WIDE_W-1:0]   WIDE_POLY_LOW   = 16'h002D; // x^5+x^3+x^2+1
  localparam logic [NARROW_W-1:0] NARROW_POLY_LOW = 14'h002B; // x^5+x^3+x+1

  // strobes from control to datapath
  typedef struct packed {
    logic ldNarrow1;  // load stage-1 register of the narrow lane
    logic ldWide1;    // load stage-1 register of the wide lane
    logic ldNarrow2;  // load stage-2 register of the narrow lane
    logic ldWide2;    // load stage-2 register of the wide lane
    logic selWide;    // output mux picks the wide lane
    logic outEn;      // output carries a result
  } gfmStrobes_t;

endpackage

// File: rtl/gfm_lane.sv
module gfm_lane #(
  parameter int          W        = 16,
  parameter logic [W-1:0] POLY_LOW = 'h2D
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ld1,
  input  logic         ld2,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);

  localparam int PW    = 2 * W - 1;       // carry-less product width
  localparam int SPLIT = W + (W - 1) / 2; // degrees at or above this fold in stage 1

  // stage 1: carry-less multiply, then clear degrees PW-1 .. SPLIT
  function automatic logic [SPLIT-1:0] foldHigh(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [PW-1:0] acc;
    acc = '0;
    for (int i = 0; i < W; i++) begin
      if (y[i]) acc ^= PW'(x) << i;
    end
    for (int d = PW - 1; d >= SPLIT; d--) begin
      if (acc[d]) acc ^= PW'({1'b1, POLY_LOW}) << (d - W);
    end
    return acc[SPLIT-1:0];
  endfunction

  // stage 2: clear degrees SPLIT-1 .. W
  function automatic logic [W-1:0] foldLow(input logic [SPLIT-1:0] x);
    logic [SPLIT-1:0] acc;
    acc = x;
    for (int d = SPLIT - 1; d >= W; d--) begin
      if (acc[d]) acc ^= SPLIT'({1'b1, POLY_LOW}) << (d - W);
    end
    return acc[W-1:0];
  endfunction

  logic [SPLIT-1:0] midQ;
  logic [SPLIT-1:0] midD;
  logic [W-1:0]     resD;

  always_comb midD = foldHigh(a, b);
  always_comb resD = foldLow(midQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    midQ <= '0;
    else if (ld1) midQ <= midD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    res <= '0;
    else if (ld2) res <= resD;
  end

endmodule

// File: rtl/gfm_ctrl.sv
module gfm_ctrl
  import gfm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  input  logic        fieldSel,
  output gfmStrobes_t strobes,
  output logic        validOut
);

  logic valid1, wide1, valid2, wide2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid1 <= 1'b0;
      wide1  <= 1'b0;
      valid2 <= 1'b0;
      wide2  <= 1'b0;
    end else begin
      valid1 <= validIn;
      wide1  <= fieldSel;
      valid2 <= valid1;
      wide2  <= wide1;
    end
  end

  // only the lane in use is clocked forward
  always_comb begin
    strobes.ldNarrow1 = validIn & ~fieldSel;
    strobes.ldWide1   = validIn &  fieldSel;
    strobes.ldNarrow2 = valid1  & ~wide1;
    strobes.ldWide2   = valid1  &  wide1;
    strobes.selWide   = wide2;
    strobes.outEn     = valid2;
  end

  assign validOut = valid2;

endmodule

// File: rtl/gfm_datapath.sv
module gfm_datapath
  import gfm_pkg::*;
#(
  parameter int                   WIDE_W      = gfm_pkg::WIDE_W,
  parameter int                   NARROW_W    = gfm_pkg::NARROW_W,
  parameter logic [WIDE_W-1:0]    WIDE_POLY   = gfm_pkg::WIDE_POLY_LOW,
  parameter logic [NARROW_W-1:0]  NARROW_POLY = gfm_pkg::NARROW_POLY_LOW
) (
  input  logic              clk,
  input  logic              rstN,
  input  gfmStrobes_t       strobes,
  input  logic [WIDE_W-1:0] opA,
  input  logic [WIDE_W-1:0] opB,
  output logic [WIDE_W-1:0] product
);

  localparam int PAD_W = WIDE_W - NARROW_W;

  logic [WIDE_W-1:0]   wideRes;
  logic [NARROW_W-1:0] narrowRes;

  gfm_lane #(.W(WIDE_W), .POLY_LOW(WIDE_POLY)) u_wide (
    .clk (clk),
    .rstN(rstN),
    .ld1 (strobes.ldWide1),
    .ld2 (strobes.ldWide2),
    .a   (opA),
    .b   (opB),
    .res (wideRes)
  );

  gfm_lane #(.W(NARROW_W), .POLY_LOW(NARROW_POLY)) u_narrow (
    .clk (clk),
    .rstN(rstN),
    .ld1 (strobes.ldNarrow1),
    .ld2 (strobes.ldNarrow2),
    .a   (opA[NARROW_W-1:0]),
    .b   (opB[NARROW_W-1:0]),
    .res (narrowRes)
  );

  always_comb begin
    if (!strobes.outEn)      product = '0;
    else if (strobes.selWide) product = wideRes;
    else                      product = {{PAD_W{1'b0}}, narrowRes};
  end

endmodule

// File: rtl/gf_dual_mul.sv
module gf_dual_mul
  import gfm_pkg::*;
#(
  parameter int                  WIDE_W      = gfm_pkg::WIDE_W,
  parameter int                  NARROW_W    = gfm_pkg::NARROW_W,
  parameter logic [WIDE_W-1:0]   WIDE_POLY   = gfm_pkg::WIDE_POLY_LOW,
  parameter logic [NARROW_W-1:0] NARROW_POLY = gfm_pkg::NARROW_POLY_LOW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic              fieldSel,
  input  logic [WIDE_W-1:0] opA,
  input  logic [WIDE_W-1:0] opB,
  output logic              validOut,
  output logic [WIDE_W-1:0] product
);

  gfmStrobes_t strobes;

  gfm_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .validIn (validIn),
    .fieldSel(fieldSel),
    .strobes (strobes),
    .validOut(validOut)
  );

  gfm_datapath #(
    .WIDE_W     (WIDE_W),
    .NARROW_W   (NARROW_W),
    .WIDE_POLY  (WIDE_POLY),
    .NARROW_POLY(NARROW_POLY)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .opA    (opA),
    .opB    (opB),
    .product(product)
  );

endmodule

// File: rtl/gf_dual_mul_chk.sv
module gf_dual_mul_chk #(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              validIn,
  input logic              fieldSel,
  input logic [WIDE_W-1:0] opA,
  input logic [WIDE_W-1:0] opB,
  input logic              validOut,
  input logic [WIDE_W-1:0] product
);

  // edges seen since reset release, saturating at 2
  logic [1:0] age;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  p_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd2) |-> (validOut == $past(validIn, 2)));

  p_narrow_top_r5: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd2 && validOut && !$past(fieldSel, 2)) |-> (product[WIDE_W-1:NARROW_W] == '0));

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> (product == '0));

  p_identity_r8: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd2 && validOut && $past(fieldSel, 2) && $past(opA, 2) == WIDE_W'(1))
      |-> (product == $past(opB, 2)));

  p_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd2 && validOut && $past(opB, 2) == '0) |-> (product == '0));

  // R7: outputs quiet while reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      p_reset_r7: assert (!validOut && product == '0);
    end
  end

endmodule

bind gf_dual_mul gf_dual_mul_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (.*);

// File: tb/tb_gf_dual_mul.sv
module tb_gf_dual_mul;

  localparam int CLK_PERIOD = 10;
  localparam int WW = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic          validIn, fieldSel;
  logic [WW-1:0] opA, opB;
  logic          validOut;
  logic [WW-1:0] product;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic          histV [2];
  logic [WW-1:0] histP [2];
  string         histT [2];

  gf_dual_mul dut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .fieldSel(fieldSel),
    .opA(opA), .opB(opB), .validOut(validOut), .product(product)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bit-serial reference: Horner over the bits of y, reduce after each shift
  function automatic logic [WW-1:0] refMul(input logic [WW-1:0] x, input logic [WW-1:0] y, input bit wide);
    int          w;
    logic [16:0] poly;
    logic [16:0] r;
    logic [16:0] xm;
    w    = wide ? 16 : 14;
    poly = wide ? 17'h1002D : 17'h0402B;
    xm   = wide ? {1'b0, x} : {3'b000, x[13:0]};
    r    = '0;
    for (int i = w - 1; i >= 0; i--) begin
      r = r << 1;
      if (r[w]) r ^= poly;
      if (y[i]) r ^= xm;
    end
    return r[WW-1:0];
  endfunction

  task automatic check(input string tag, input logic expV, input logic [WW-1:0] expP);
    total++;
    if (validOut !== expV || product !== expP) begin
      bad++;
      $display("FAIL %s: validOut=%0b product=%h expected validOut=%0b product=%h",
               tag, validOut, product, expV, expP);
    end
  endtask

  task automatic step(input logic v, input logic f, input logic [WW-1:0] a,
                      input logic [WW-1:0] b, input string tag);
    @(negedge clk);
    check(histT[1], histV[1], histP[1]);
    histV[1] = histV[0]; histP[1] = histP[0]; histT[1] = histT[0];
    histV[0] = v;
    histP[0] = v ? refMul(a, b, f) : '0;
    histT[0] = v ? tag : "R6";
    validIn = v; fieldSel = f; opA = a; opB = b;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R4 watchdog: finished=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; validIn = 1'b0; fieldSel = 1'b0; opA = '0; opB = '0;
    for (int k = 0; k < 2; k++) begin histV[k] = 1'b0; histP[k] = '0; histT[k] = "R6"; end
    // R7: reset state
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R7", 1'b0, '0);
    end
    rstN = 1'b1;

    // R1 / R8: wide directed corners
    step(1, 1, 16'hFFFF, 16'hFFFF, "R1");
    step(1, 1, 16'h8000, 16'h0002, "R1");
    step(1, 1, 16'h0001, 16'hBEEF, "R8");
    step(1, 1, 16'h1234, 16'h0000, "R8");
    step(0, 0, '0, '0, "R6");
    // R2 / R5: narrow corners with junk in bits 15:14
    step(1, 0, 16'h2000, 16'h0002, "R2");
    step(1, 0, 16'h3FFF, 16'h3FFF, "R2");
    step(1, 0, 16'hFFFF, 16'hFFFF, "R5");
    step(1, 0, 16'hC001, 16'h8ABC, "R5");
    step(1, 0, 16'h4000, 16'h8000, "R5");
    step(1, 0, 16'h0001, 16'h1234, "R8");

    // R4: back-to-back, field flips every cycle
    for (int k = 0; k < 600; k++) begin
      step(1, k[0], 16'($urandom), 16'($urandom), k[0] ? "R4" : "R5");
    end
    // R3: random bubbles and random fields
    for (int k = 0; k < 600; k++) begin
      step(1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom), "R3");
    end
    // drain
    for (int k = 0; k < 3; k++) step(0, 0, '0, '0, "R6");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule